// File: doc/BRIEF.md
# Tag-Side Load Modulator

This block is the reply transmitter of a low-frequency transponder. It drives a single load-modulation level, `mod_out`, and forms a complete reply frame from a bit stream. Each frame has four parts in order. First the output is held high for a lead-in. Then come optional start-of-frame symbols, then the data symbols with the most significant bit first. Last, the output is driven low. All timing is counted in carrier periods, and each carrier period is marked by a one-cycle `tick` strobe from the surrounding logic.

Four line codes are available. Two are burst codes: a zero is one long high/low pair and a one is two short pairs. Two are split-phase codes: a zero is low then high, and a one is high then low. The code for a frame and its start-marker length are taken together with the first data bit through a ready/valid handshake. The following bits arrive through the same handshake and go into a one-entry prefetch register. A bit flagged as last closes the frame. When the frame is complete, `done` pulses for one clock cycle.

Top module: `lm_reply_tx`

## Requirements
- R1: Synchronous reset drives `mod_out` low and `done` low, and leaves the block idle with `in_ready` high.
- R2: On the clock edge that accepts the first bit of a frame, `mod_out` goes high. It stays high for the lead-in: 40 ticks in modes 1 and 3, and 20 ticks in modes 0 and 2.
- R3: Mode 0 uses 64-tick symbols. A zero is high for ticks 0..31 and low for 32..63. A one is high, low, high, low, changing at ticks 16, 32 and 48.
- R4: Mode 1 uses 32-tick symbols. A zero is high for 0..15 and low for 16..31. A one changes level at ticks 8, 16 and 24, starting high.
- R5: Mode 2 uses 32-tick symbols. A zero is low for 0..15 and high for 16..31. A one is high for 0..15 and low for 16..31.
- R6: Mode 3 uses the shapes of R5 with 16-tick symbols, changing level at tick 8.
- R7: The start marker is `sof_len` one-symbols (0 to 7). When `sof_len` is 0, the data follows the lead-in directly.
- R8: When `sof_len` is 4, the marker is three symbols: one, one, zero.
- R9: Data symbols follow in acceptance order, one per accepted bit. Each symbol starts its tick count from zero, with no gap after the previous symbol.
- R10: After the last symbol, `mod_out` is low on the next tick. On the tick after that, `done` is high for exactly one clock cycle.
- R11: `mode` and `sof_len` are sampled only when a frame starts. Changing them during the frame has no effect on its waveform.
- R12: If no bit is waiting when a data symbol ends and the last bit has not yet been flagged, the frame ends as if the previous bit had been the last.
- R13: `mod_out` changes only on a clock edge where `tick` is high or a frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle strobe per carrier period |
| in_valid | input | 1 | A bit is offered |
| in_ready | output | 1 | The block takes the offered bit on this edge |
| in_bit | input | 1 | Data bit, most significant first |
| in_last | input | 1 | Marks the final bit of the frame |
| mode | input | 2 | Line code: 0 burst-64, 1 burst-32, 2 split-32, 3 split-16 |
| sof_len | input | SOF_W | Start-marker length in symbols |
| mod_out | output | 1 | Load-modulation level |
| done | output | 1 | One-cycle pulse when the frame is complete |

## Verification
A wrong phase counter or a wrong mode register shows at `mod_out` within one symbol, at most 64 ticks. A lead-in of the wrong length shifts every later edge of the frame, so the first symbol after the lead-in already shows the error. A faulty prefetch or marker counter adds, drops or inverts a whole symbol, which moves the frame end and the `done` pulse by a symbol length. A stuck end-of-frame state shows as a missing or doubled `done` one tick after the output goes low.

// File: rtl/lm_pkg.sv
package lm_pkg;

  typedef enum logic [1:0] {
    LM_BURST64 = 2'd0,
    LM_BURST32 = 2'd1,
    LM_SPLIT32 = 2'd2,
    LM_SPLIT16 = 2'd3
  } lm_mode_e;

  typedef enum logic [2:0] {
    LS_IDLE = 3'd0,
    LS_LEAD = 3'd1,
    LS_MARK = 3'd2,
    LS_DATA = 3'd3,
    LS_TAIL = 3'd4
  } lm_state_e;

  localparam int LM_CNT_W = 7;
  typedef logic [LM_CNT_W-1:0] lm_cnt_t;

  // a quarter of a symbol, in carrier ticks
  function automatic lm_cnt_t lm_quarter(lm_mode_e m);
    case (m)
      LM_BURST64: return lm_cnt_t'(16);
      LM_SPLIT16: return lm_cnt_t'(4);
      default:    return lm_cnt_t'(8);
    endcase
  endfunction

  function automatic lm_cnt_t lm_sym_ticks(lm_mode_e m);
    return lm_quarter(m) << 2;
  endfunction

  function automatic lm_cnt_t lm_lead_ticks(lm_mode_e m);
    return (m == LM_BURST32 || m == LM_SPLIT16) ? lm_cnt_t'(40) : lm_cnt_t'(20);
  endfunction

  // output level of a symbol at a given tick phase
  function automatic logic lm_level(lm_mode_e m, logic b, lm_cnt_t ph);
    lm_cnt_t q;
    lm_cnt_t half;
    logic    first;
    q     = lm_quarter(m);
    half  = q << 1;
    first = (ph < half);
    if (!m[1]) begin
      if (b) return (ph < q) || (!first && (ph < half + q));
      else   return first;
    end
    return b ? first : !first;
  endfunction

endpackage

// File: rtl/lm_sym_timer.sv
module lm_sym_timer
  import lm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     start_lead,
  input  logic     start_sym,
  input  logic     stop,
  input  lm_mode_e mode,
  input  logic     sym_bit,
  output logic     out_q,
  output logic     sym_end
);

  lm_cnt_t cnt;
  lm_cnt_t last;
  lm_cnt_t cnt_nxt;
  logic    active;
  logic    is_lead;
  logic    bit_q;

  assign last    = (is_lead ? lm_lead_ticks(mode) : lm_sym_ticks(mode)) - lm_cnt_t'(1);
  assign cnt_nxt = cnt + lm_cnt_t'(1);
  assign sym_end = active && tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      active  <= 1'b0;
      is_lead <= 1'b0;
      bit_q   <= 1'b0;
      out_q   <= 1'b0;
    end else if (start_lead) begin
      cnt     <= '0;
      active  <= 1'b1;
      is_lead <= 1'b1;
      out_q   <= 1'b1;
    end else if (start_sym) begin
      cnt     <= '0;
      active  <= 1'b1;
      is_lead <= 1'b0;
      bit_q   <= sym_bit;
      out_q   <= lm_level(mode, sym_bit, '0);
    end else if (stop) begin
      active  <= 1'b0;
      out_q   <= 1'b0;
    end else if (active && tick) begin
      cnt <= cnt_nxt;
      if (!is_lead) out_q <= lm_level(mode, bit_q, cnt_nxt);
    end
  end

  // R2: the lead-in keeps the load applied
  a_r2_lead_high: assert property (@(posedge clk) disable iff (rst)
    (active && is_lead) |-> out_q);

  // R13: no level change without a tick or a new symbol
  a_r13_quiet_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start_lead && !start_sym && !stop) |=> $stable(out_q));

  // R9: the phase never runs past the end of the symbol
  a_r9_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= last));

endmodule

// File: rtl/lm_frame_seq.sv
module lm_frame_seq
  import lm_pkg::*;
#(
  parameter int SOF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             in_last,
  input  lm_mode_e         mode_i,
  input  logic [SOF_W-1:0] sof_len_i,
  input  logic             sym_end,
  output logic             in_ready,
  output logic             start_lead,
  output logic             start_sym,
  output logic             stop,
  output logic             sym_bit,
  output lm_mode_e         mode_q,
  output logic             done
);

  localparam logic [SOF_W-1:0] SPECIAL_LEN = SOF_W'(4);
  localparam logic [SOF_W-1:0] SPECIAL_SYM = SOF_W'(3);
  localparam logic [SOF_W-1:0] ZERO_POS    = SOF_W'(2);

  lm_state_e        state;
  logic [SOF_W-1:0] sof_q;
  logic [SOF_W-1:0] mark_idx;
  logic [SOF_W-1:0] mark_total;
  logic [SOF_W-1:0] idx_next;
  logic             buf_vld;
  logic             buf_bit;
  logic             closed;
  logic             want_mark;
  logic             take_data;
  logic             busy_sym;
  logic             accept;

  assign busy_sym   = (state == LS_LEAD) || (state == LS_MARK) || (state == LS_DATA);
  assign mark_total = (sof_q == SPECIAL_LEN) ? SPECIAL_SYM : sof_q;
  assign idx_next   = (state == LS_LEAD) ? '0 : mark_idx + SOF_W'(1);
  assign want_mark  = sym_end && (((state == LS_LEAD) && (mark_total != '0)) ||
                                  ((state == LS_MARK) && (idx_next < mark_total)));
  assign take_data  = sym_end && !want_mark && buf_vld;
  assign stop       = sym_end && !want_mark && !buf_vld;
  assign start_sym  = want_mark || take_data;
  assign sym_bit    = want_mark ? !((sof_q == SPECIAL_LEN) && (idx_next == ZERO_POS)) : buf_bit;
  assign start_lead = (state == LS_IDLE) && in_valid;
  assign in_ready   = (state == LS_IDLE) || (busy_sym && !buf_vld && !closed && !sym_end);
  assign accept     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LS_IDLE;
      mode_q   <= LM_BURST64;
      sof_q    <= '0;
      mark_idx <= '0;
      buf_vld  <= 1'b0;
      buf_bit  <= 1'b0;
      closed   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= (state == LS_TAIL) && tick;
      if (state == LS_IDLE) begin
        if (in_valid) begin
          mode_q  <= mode_i;
          sof_q   <= sof_len_i;
          buf_vld <= 1'b1;
          buf_bit <= in_bit;
          closed  <= in_last;
          state   <= LS_LEAD;
        end
      end else if (state == LS_TAIL) begin
        if (tick) state <= LS_IDLE;
      end else begin
        if (accept) begin
          buf_vld <= 1'b1;
          buf_bit <= in_bit;
          closed  <= in_last;
        end
        if (want_mark) begin
          state    <= LS_MARK;
          mark_idx <= idx_next;
        end
        if (take_data) begin
          state   <= LS_DATA;
          buf_vld <= 1'b0;
        end
        if (stop) begin
          state   <= LS_TAIL;
          buf_vld <= 1'b0;
        end
      end
    end
  end

  // R11: the line code is frozen while a frame runs
  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (state != LS_IDLE) |=> $stable(mode_q));

  // R9: at most one timer command per cycle
  a_r9_one_command: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_lead, start_sym, stop}));

  // R10: completion is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/lm_reply_tx.sv
module lm_reply_tx
  import lm_pkg::*;
#(
  parameter int SOF_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  input  logic             in_last,
  input  logic [1:0]       mode,
  input  logic [SOF_W-1:0] sof_len,
  output logic             mod_out,
  output logic             done
);

  logic     start_lead;
  logic     start_sym;
  logic     stop;
  logic     sym_bit;
  logic     sym_end;
  lm_mode_e mode_q;

  lm_frame_seq #(.SOF_W(SOF_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .in_valid  (in_valid),
    .in_bit    (in_bit),
    .in_last   (in_last),
    .mode_i    (lm_mode_e'(mode)),
    .sof_len_i (sof_len),
    .sym_end   (sym_end),
    .in_ready  (in_ready),
    .start_lead(start_lead),
    .start_sym (start_sym),
    .stop      (stop),
    .sym_bit   (sym_bit),
    .mode_q    (mode_q),
    .done      (done)
  );

  lm_sym_timer u_tmr (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start_lead(start_lead),
    .start_sym (start_sym),
    .stop      (stop),
    .mode      (mode_q),
    .sym_bit   (sym_bit),
    .out_q     (mod_out),
    .sym_end   (sym_end)
  );

  // R10: completion is reported only with the load released
  a_r10_done_low: assert property (@(posedge clk) disable iff (rst)
    done |-> !mod_out);

  // R1: the first cycle after reset is quiet and ready
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mod_out && !done && in_ready));

endmodule

// File: tb/lm_reply_tx_test.sv
`timescale 1ns/1ps
module lm_reply_tx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_bit = 1'b0;
  logic       in_last = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] sof_len = 3'd0;
  logic       mod_out;
  logic       done;

  logic tick_seen = 1'b0;
  logic acc_seen = 1'b0;

  int checks = 0;
  int errors = 0;
  int exp_lv [0:4095];
  int sec    [0:4095];
  int got    [0:4095];
  int exp_len;
  bit fbits  [0:63];
  bit done_bad;
  bit done_end;

  lm_reply_tx uut (
    .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_last(in_last), .mode(mode), .sof_len(sof_len),
    .mod_out(mod_out), .done(done)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    tick_seen <= tick;
    acc_seen  <= in_valid && in_ready;
    tick      <= ($urandom % 2) == 0;
  end

  function automatic int b_unit(int m);
    if (m == 0) return 16;
    if (m == 3) return 4;
    return 8;
  endfunction

  function automatic int b_level(int m, int b, int p);
    int slot = p / b_unit(m);
    if (m < 2) return b ? ((slot % 2) == 0) : (slot < 2);
    return b ? (slot < 2) : (slot >= 2);
  endfunction

  function automatic int b_lead(int m);
    return (m == 1 || m == 3) ? 40 : 20;
  endfunction

  function automatic string mode_req(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(int v, int s);
    exp_lv[exp_len] = v;
    sec[exp_len] = s;
    exp_len++;
  endtask

  task automatic build(int m, int sl, int nb);
    int nmark = (sl == 4) ? 3 : sl;
    exp_len = 0;
    for (int i = 0; i < b_lead(m); i++) push(1, 0);
    for (int j = 0; j < nmark; j++) begin
      int b = (sl == 4 && j == 2) ? 0 : 1;
      for (int p = 0; p < 4 * b_unit(m); p++) push(b_level(m, b, p), 1);
    end
    for (int i = 0; i < nb; i++)
      for (int p = 0; p < 4 * b_unit(m); p++) push(b_level(m, fbits[i], p), 2);
    push(0, 3);
  endtask

  task automatic feeder(int m, int sl, int nb, bit scr, bit trunc);
    @(negedge clk);
    mode = m[1:0];
    sof_len = sl[2:0];
    for (int i = 0; i < nb; i++) begin
      in_valid = 1'b1;
      in_bit   = fbits[i];
      in_last  = (i == nb - 1) && !trunc;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (scr && i == 0) begin
        mode = mode + 2'd1;
        sof_len = sof_len + 3'd3;
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic monitor();
    int k;
    @(negedge clk);
    while (!acc_seen) @(negedge clk);
    got[0] = mod_out;
    if (done) done_bad = 1;
    k = 1;
    while (k <= exp_len) begin
      @(negedge clk);
      if (tick_seen) begin
        if (k < exp_len) begin
          got[k] = mod_out;
          if (done) done_bad = 1;
        end else begin
          done_end = done;
        end
        k++;
      end else if (done) begin
        done_bad = 1;
      end
    end
  endtask

  task automatic run_frame(int m, int sl, int nb, bit scr, bit trunc);
    int bad_at [0:3];
    int any_bad;
    for (int i = 0; i < nb; i++) fbits[i] = ($urandom % 2) == 1;
    build(m, sl, nb);
    done_bad = 0;
    done_end = 0;
    fork
      feeder(m, sl, nb, scr, trunc);
      monitor();
    join
    for (int s = 0; s < 4; s++) bad_at[s] = -1;
    any_bad = -1;
    for (int i = 0; i < exp_len; i++) begin
      if (got[i] != exp_lv[i]) begin
        if (bad_at[sec[i]] < 0) bad_at[sec[i]] = i;
        if (any_bad < 0) any_bad = i;
      end
    end
    check(bad_at[0] < 0, "R2", $sformatf("lead-in mode %0d tick %0d", m, bad_at[0]),
          bad_at[0] < 0 ? 1 : got[bad_at[0]], bad_at[0] < 0 ? 1 : exp_lv[bad_at[0]]);
    check(bad_at[1] < 0, (sl == 4) ? "R8" : "R7", $sformatf("start marker len %0d tick %0d", sl, bad_at[1]),
          bad_at[1] < 0 ? 0 : got[bad_at[1]], bad_at[1] < 0 ? 0 : exp_lv[bad_at[1]]);
    check(bad_at[2] < 0, {mode_req(m), " R9"}, $sformatf("data mode %0d tick %0d", m, bad_at[2]),
          bad_at[2] < 0 ? 0 : got[bad_at[2]], bad_at[2] < 0 ? 0 : exp_lv[bad_at[2]]);
    check(bad_at[3] < 0, "R10", "output low after last symbol",
          got[exp_len-1], 0);
    check(done_end && !done_bad, "R10", "done pulse position", done_end, 1);
    if (scr)
      check(any_bad < 0, "R11", "frame unaffected by mode/sof_len change", any_bad, -1);
    if (trunc)
      check(any_bad < 0, "R12", "frame ended by underrun", any_bad, -1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5417));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    check(mod_out == 1'b0, "R1", "mod_out after reset", mod_out, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // directed: every mode with plain, absent and special markers
    for (int m = 0; m < 4; m++) begin
      run_frame(m, 3, 5, 0, 0);
      run_frame(m, 4, 3, 0, 0);
      run_frame(m, 0, 2, 0, 0);
    end
    run_frame(3, 7, 1, 1, 0);
    run_frame(1, 4, 4, 0, 1);

    // random frames
    for (int n = 0; n < 10; n++)
      run_frame($urandom % 4, $urandom % 8, 1 + $urandom % 12, $urandom % 2, $urandom % 2);

    // R1: reset in the middle of a lead-in
    @(negedge clk);
    mode = 2'd1; in_valid = 1'b1; in_bit = 1'b1; in_last = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (20) @(negedge clk);
    check(mod_out == 1'b1, "R2", "lead-in still high before reset", mod_out, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(mod_out == 1'b0, "R1", "mod_out after mid-frame reset", mod_out, 0);
    check(in_ready == 1'b1, "R1", "in_ready after mid-frame reset", in_ready, 1);
    repeat (100) @(negedge clk);
    // R13: with no frame running the output stays put across ticks
    check(mod_out == 1'b0 && done == 1'b0, "R13", "idle output after reset", mod_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule